// File: doc/BRIEF.md
# Byte-Window Host Port to Coprocessor Shared RAM

This block lets a host processor reach the local RAM of an attached coprocessor through four byte-wide registers instead of a wide memory window. The host loads a 16-bit pointer one byte at a time. It then reads or writes a data register, and each such access touches the RAM byte the pointer selects. When the auto-step option is on, the pointer moves to the next byte after every data access. Whole buffers can then be uploaded, read back or compared with no pointer reloads in between.

A fourth register combines control and status. The host writes it to let the coprocessor run and to enable auto-step. It also uses this register to select a pass-through mode for a peripheral behind the coprocessor, and to raise a doorbell toward the coprocessor. The coprocessor posts two event flags into the same register and the host clears them by writing ones. The two flags share one host interrupt output. The RAM is an internal array of which the low `RAM_AW` pointer bits select a byte.

Host accesses are run by a four-state machine:
- `ST_IDLE` accepts requests.
- A data read goes `ST_IDLE -> ST_RAM_RD` and a data write goes `ST_IDLE -> ST_RAM_WR`.
- Both RAM states go to `ST_ADVANCE` when auto-step is on and back to `ST_IDLE` otherwise.
- `ST_ADVANCE` bumps the pointer and returns to `ST_IDLE`.
- Pointer and control register accesses complete in `ST_IDLE` without leaving it.

Top module: `shram_host_port`

## Requirements
- R1: After reset the pointer is 0x0000, the control/status register reads 0x00, `host_ready` is 1 and `cop_run`, `bypass_sel`, `cop_irq` and `host_irq` are 0.
- R2: Register select 0 holds pointer bits 7:0 and select 1 holds bits 15:8. Each is written and read back separately. A register read returns its value on `host_rdata` with `host_rvalid` high in the cycle after the accepting edge.
- R3: Register select 2 is the data register. A write stores the byte at RAM[pointer]. A read returns RAM[pointer] with `host_rvalid` high two cycles after the accepting edge.
- R4: With auto-step on, the pointer rises by one after every data access, both reads and writes. With auto-step off, the pointer is left unchanged.
- R5: Auto-step wraps the pointer from 0xFFFF to 0x0000.
- R6: Register select 3 is control/status. Bit 0 run drives `cop_run`, bit 1 enables auto-step and bit 2 drives `bypass_sel`. These bits take the written value and read back.
- R7: Writing 1 to bit 3 (doorbell) sets `cop_irq`. Writing 0 there has no effect. `cop_irq_ack` clears it, and a host write of 1 in the same cycle wins over the acknowledge.
- R8: A pulse on `cop_int0_set` or `cop_int1_set` sets flag bit 4 or bit 5. `host_irq` is high while either flag is set.
- R9: Writing 1 to bit 4 or bit 5 clears that flag and writing 0 leaves it unchanged. A set pulse in the same cycle as the clearing write leaves the flag set.
- R10: `host_ready` is low from the edge that accepts a data access until the access, including the pointer step, is done. Requests presented while `host_ready` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request strobe, taken when host_ready is high |
| host_write | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 data, 3 control/status |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Port idle and able to take a request |
| host_rvalid | output | 1 | Read data valid, one-cycle pulse |
| host_rdata | output | 8 | Read byte |
| cop_int0_set | input | 1 | Coprocessor event pulse for flag 0 |
| cop_int1_set | input | 1 | Coprocessor event pulse for flag 1 |
| cop_irq_ack | input | 1 | Coprocessor acknowledges the doorbell |
| cop_run | output | 1 | Coprocessor may execute |
| cop_irq | output | 1 | Doorbell toward the coprocessor |
| bypass_sel | output | 1 | Pass-through mode select for the attached peripheral |
| host_irq | output | 1 | OR of both event flags |

## Verification
The hardest case to reach from the ports is a coprocessor set pulse that lands in the same clock as a host write-one-to-clear of the same flag. The bench bypasses its usual bus task here. It drives the control write and the set pulse on the same falling edge, so that both meet the same accepting edge. The second hard case is a request made while a data access is still running. The bench presents a pointer write on the falling edge right after a data write is accepted, while `host_ready` is low. It then reads the pointer back to show that the request was dropped and the auto-step still happened.

// File: rtl/shram_port_pkg.sv
package shram_port_pkg;

    localparam int HOST_DW = 8;
    localparam int SEL_W   = 2;

    // Register select codes seen by the host.
    typedef enum logic [SEL_W-1:0] {
        REG_PTR_LO = 2'd0,
        REG_PTR_HI = 2'd1,
        REG_DATA   = 2'd2,
        REG_CSR    = 2'd3
    } reg_sel_e;

    // Bit positions inside the control/status register.
    localparam int CSR_RUN     = 0;
    localparam int CSR_AUTOINC = 1;
    localparam int CSR_BYPASS  = 2;
    localparam int CSR_KICK    = 3;
    localparam int CSR_FLAG0   = 4;
    localparam int N_FLAGS     = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RAM_RD  = 2'd1,
        ST_RAM_WR  = 2'd2,
        ST_ADVANCE = 2'd3
    } acc_state_e;

endpackage

// File: rtl/shram_ptr.sv
// Byte-loadable RAM pointer with single-step advance.
module shram_ptr #(
    parameter int PTR_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     load_en,
    input  logic [((PTR_W/BYTE_W) > 1 ? $clog2(PTR_W/BYTE_W) : 1)-1:0] load_lane,
    input  logic [BYTE_W-1:0]                        load_byte,
    input  logic                                     step,
    output logic [PTR_W-1:0]                         ptr_q
);
    localparam int N_LANES = PTR_W / BYTE_W;

    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (step) begin
            ptr_d = ptr_q + 1'b1;
        end
        for (int i = 0; i < N_LANES; i++) begin
            if (load_en && (int'(load_lane) == i)) begin
                ptr_d[i*BYTE_W +: BYTE_W] = load_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // R5: stepping off the top of the range lands at zero
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en && (ptr_q == {PTR_W{1'b1}})) |=> (ptr_q == '0));

    // R4: with no load and no step the pointer keeps its value
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_en) |=> $stable(ptr_q));

endmodule

// File: rtl/shram_csr.sv
// Control/status register: plain control bits, doorbell, write-1-to-clear flags.
module shram_csr
    import shram_port_pkg::*;
#(
    parameter int DW = HOST_DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DW-1:0]      wdata,
    input  logic [N_FLAGS-1:0] flag_set,
    input  logic               kick_ack,
    output logic [DW-1:0]      csr_rd,
    output logic               run,
    output logic               autoinc,
    output logic               bypass,
    output logic               kick,
    output logic [N_FLAGS-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run     <= 1'b0;
            autoinc <= 1'b0;
            bypass  <= 1'b0;
        end else if (wr_en) begin
            run     <= wdata[CSR_RUN];
            autoinc <= wdata[CSR_AUTOINC];
            bypass  <= wdata[CSR_BYPASS];
        end
    end

    // Doorbell: host sets, coprocessor clears; a host set wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kick <= 1'b0;
        end else if (wr_en && wdata[CSR_KICK]) begin
            kick <= 1'b1;
        end else if (kick_ack) begin
            kick <= 1'b0;
        end
    end

    p_kick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !kick_ack) |=> kick);

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (flag_set[g]) begin
                flags[g] <= 1'b1;
            end else if (wr_en && wdata[CSR_FLAG0+g]) begin
                flags[g] <= 1'b0;
            end
        end

        // R8: an event pulse always leaves the flag set
        p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            flag_set[g] |=> flags[g]);

        // R9: a write of one without a competing set clears the flag
        p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wdata[CSR_FLAG0+g] && !flag_set[g]) |=> !flags[g]);

        // R9: a set flag survives anything but a write of one
        p_flag_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !(wr_en && wdata[CSR_FLAG0+g])) |=> flags[g]);
    end

    always_comb begin
        csr_rd = '0;
        csr_rd[CSR_RUN]     = run;
        csr_rd[CSR_AUTOINC] = autoinc;
        csr_rd[CSR_BYPASS]  = bypass;
        csr_rd[CSR_KICK]    = kick;
        csr_rd[CSR_FLAG0 +: N_FLAGS] = flags;
    end

endmodule

// File: rtl/shram_store.sv
// Byte-wide coprocessor RAM model: synchronous write, combinational read.
module shram_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/shram_host_port.sv
// Host-side indirect access port into coprocessor shared RAM.
module shram_host_port
    import shram_port_pkg::*;
#(
    parameter int RAM_AW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_valid,
    input  logic         host_write,
    input  logic [1:0]   host_reg,
    input  logic [7:0]   host_wdata,
    output logic         host_ready,
    output logic         host_rvalid,
    output logic [7:0]   host_rdata,
    input  logic         cop_int0_set,
    input  logic         cop_int1_set,
    input  logic         cop_irq_ack,
    output logic         cop_run,
    output logic         cop_irq,
    output logic         bypass_sel,
    output logic         host_irq
);
    localparam int PTR_W  = 16;
    localparam int BYTE_W = HOST_DW;

    acc_state_e state_q, state_d;

    logic              accept;
    logic              ptr_load, ptr_step, ram_we, csr_wr, autoinc;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] wbyte_q, ram_rd, csr_rd, reg_rd;
    logic [N_FLAGS-1:0] flags;
    reg_sel_e          sel;

    assign sel    = reg_sel_e'(host_reg);
    assign accept = host_valid && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && (sel == REG_DATA)) begin
                    state_d = host_write ? ST_RAM_WR : ST_RAM_RD;
                end
            end
            ST_RAM_RD, ST_RAM_WR: begin
                state_d = autoinc ? ST_ADVANCE : ST_IDLE;
            end
            ST_ADVANCE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs and strobes
    always_comb begin
        host_ready = 1'b0;
        ram_we     = 1'b0;
        ptr_step   = 1'b0;
        unique case (state_q)
            ST_IDLE:    host_ready = 1'b1;
            ST_RAM_RD:  ;
            ST_RAM_WR:  ram_we     = 1'b1;
            ST_ADVANCE: ptr_step   = 1'b1;
            default:    ;
        endcase
    end

    assign ptr_load = accept && host_write && ((sel == REG_PTR_LO) || (sel == REG_PTR_HI));
    assign csr_wr   = accept && host_write && (sel == REG_CSR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbyte_q <= '0;
        end else if (accept && host_write && (sel == REG_DATA)) begin
            wbyte_q <= host_wdata;
        end
    end

    always_comb begin
        unique case (sel)
            REG_PTR_LO: reg_rd = ptr[BYTE_W-1:0];
            REG_PTR_HI: reg_rd = ptr[PTR_W-1:BYTE_W];
            REG_CSR:    reg_rd = csr_rd;
            default:    reg_rd = '0;
        endcase
    end

    // Read return path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= 1'b0;
            if (state_q == ST_RAM_RD) begin
                host_rvalid <= 1'b1;
                host_rdata  <= ram_rd;
            end else if (accept && !host_write && (sel != REG_DATA)) begin
                host_rvalid <= 1'b1;
                host_rdata  <= reg_rd;
            end
        end
    end

    shram_ptr #(
        .PTR_W  (PTR_W),
        .BYTE_W (BYTE_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (ptr_load),
        .load_lane (host_reg[0]),
        .load_byte (host_wdata),
        .step      (ptr_step),
        .ptr_q     (ptr)
    );

    shram_csr u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_wr),
        .wdata    (host_wdata),
        .flag_set ({cop_int1_set, cop_int0_set}),
        .kick_ack (cop_irq_ack),
        .csr_rd   (csr_rd),
        .run      (cop_run),
        .autoinc  (autoinc),
        .bypass   (bypass_sel),
        .kick     (cop_irq),
        .flags    (flags)
    );

    shram_store #(
        .AW (RAM_AW),
        .DW (BYTE_W)
    ) u_store (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ptr[RAM_AW-1:0]),
        .wdata (wbyte_q),
        .rdata (ram_rd)
    );

    assign host_irq = |flags;

    // R10: a data access makes the port busy on the next cycle
    p_busy_after_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (sel == REG_DATA)) |=> !host_ready);

    // R10: requests during a RAM phase leave the pointer alone
    p_ignored_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && ((state_q == ST_RAM_RD) || (state_q == ST_RAM_WR))) |=> $stable(ptr));

    // R3: data read returns after exactly two edges
    p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !host_write && (sel == REG_DATA)) |=> (!host_rvalid ##1 host_rvalid));

    // R2: register reads return in the following cycle
    p_reg_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !host_write && (sel != REG_DATA)) |=> host_rvalid);

endmodule

// File: tb/test_shram_host_port.sv
`timescale 1ns/1ps
module test_shram_host_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_valid = 1'b0;
    logic       host_write = 1'b0;
    logic [1:0] host_reg = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_ready, host_rvalid;
    logic [7:0] host_rdata;
    logic       cop_int0_set = 1'b0;
    logic       cop_int1_set = 1'b0;
    logic       cop_irq_ack = 1'b0;
    logic       cop_run, cop_irq, bypass_sel, host_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    shram_host_port i_shram_host_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_valid   (host_valid),
        .host_write   (host_write),
        .host_reg     (host_reg),
        .host_wdata   (host_wdata),
        .host_ready   (host_ready),
        .host_rvalid  (host_rvalid),
        .host_rdata   (host_rdata),
        .cop_int0_set (cop_int0_set),
        .cop_int1_set (cop_int1_set),
        .cop_irq_ack  (cop_irq_ack),
        .cop_run      (cop_run),
        .cop_irq      (cop_irq),
        .bypass_sel   (bypass_sel),
        .host_irq     (host_irq)
    );

    localparam logic [1:0] S_LO = 2'd0, S_HI = 2'd1, S_DAT = 2'd2, S_CSR = 2'd3;

    typedef struct packed {
        logic       wr;
        logic [1:0] sel;
        logic [7:0] val;   // write data, or expected read data
        logic [3:0] tag;   // requirement number for reads
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, S_CSR, 8'h03, 4'd0},
        '{1'b1, S_LO,  8'h10, 4'd0},
        '{1'b1, S_HI,  8'h00, 4'd0},
        '{1'b1, S_DAT, 8'hA1, 4'd0},
        '{1'b1, S_DAT, 8'hB2, 4'd0},
        '{1'b1, S_DAT, 8'hC3, 4'd0},
        '{1'b0, S_LO,  8'h13, 4'd4},   // R4 writes stepped
        '{1'b1, S_LO,  8'h10, 4'd0},
        '{1'b0, S_DAT, 8'hA1, 4'd3},   // R3
        '{1'b0, S_DAT, 8'hB2, 4'd3},
        '{1'b0, S_DAT, 8'hC3, 4'd3},
        '{1'b0, S_LO,  8'h13, 4'd4},   // R4 reads stepped
        '{1'b1, S_CSR, 8'h01, 4'd0},
        '{1'b1, S_LO,  8'h20, 4'd0},
        '{1'b1, S_DAT, 8'h5A, 4'd0},
        '{1'b0, S_DAT, 8'h5A, 4'd3},   // R3 no step
        '{1'b0, S_LO,  8'h20, 4'd4},   // R4 auto-step off
        '{1'b0, S_CSR, 8'h01, 4'd6},   // R6
        '{1'b1, S_CSR, 8'h07, 4'd0},
        '{1'b0, S_CSR, 8'h07, 4'd6},   // R6
        '{1'b0, S_HI,  8'h00, 4'd2}    // R2
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [1:0] s, input logic [7:0] d,
                       output logic [7:0] q);
        int guard;
        @(negedge clk);
        guard = 0;
        while (!host_ready && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        host_valid = 1'b1;
        host_write = wr;
        host_reg   = s;
        host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0;
        q = 8'hXX;
        if (!wr) begin
            guard = 0;
            while (!host_rvalid && guard < 10) begin
                @(negedge clk);
                guard++;
            end
            q = host_rdata;
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        logic [7:0] dummy;
        bus(1'b1, s, d, dummy);
    endtask

    task automatic rd_chk(input string req, input logic [1:0] s, input logic [7:0] exp);
        logic [7:0] q;
        bus(1'b0, s, 8'h00, q);
        check(req, q, exp);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) cop_int0_set = 1'b1;
        if (which == 1) cop_int1_set = 1'b1;
        if (which == 2) begin cop_int0_set = 1'b1; cop_int1_set = 1'b1; end
        if (which == 3) cop_irq_ack = 1'b1;
        @(negedge clk);
        cop_int0_set = 1'b0;
        cop_int1_set = 1'b0;
        cop_irq_ack  = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ready", {7'd0, host_ready}, 8'h01);
        check("R1 outputs", {4'd0, cop_run, bypass_sel, cop_irq, host_irq}, 8'h00);
        rd_chk("R1 csr", S_CSR, 8'h00);
        rd_chk("R1 ptr lo", S_LO, 8'h00);
        rd_chk("R1 ptr hi", S_HI, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            bus(VECS[i].wr, VECS[i].sel, VECS[i].val, q);
            if (!VECS[i].wr) begin
                check($sformatf("R%0d vec%0d", VECS[i].tag, i), q, VECS[i].val);
            end
        end

        // R6 port effects of csr = 0x07, then 0x00
        check("R6 run/bypass on", {6'd0, cop_run, bypass_sel}, 8'h03);
        wr(S_CSR, 8'h00);
        check("R6 run/bypass off", {6'd0, cop_run, bypass_sel}, 8'h00);

        // R2 both pointer bytes independent
        wr(S_HI, 8'h9C);
        wr(S_LO, 8'h3E);
        rd_chk("R2 hi", S_HI, 8'h9C);
        rd_chk("R2 lo", S_LO, 8'h3E);

        // R5 wrap on write and on read
        wr(S_CSR, 8'h03);
        wr(S_LO, 8'hFF);
        wr(S_HI, 8'hFF);
        wr(S_DAT, 8'h77);
        rd_chk("R5 lo wrapped", S_LO, 8'h00);
        rd_chk("R5 hi wrapped", S_HI, 8'h00);
        wr(S_DAT, 8'h88);
        wr(S_LO, 8'hFF);
        wr(S_HI, 8'hFF);
        rd_chk("R5 read top", S_DAT, 8'h77);
        rd_chk("R5 read after wrap", S_DAT, 8'h88);

        // R10 request while busy is dropped
        wr(S_LO, 8'h40);
        wr(S_HI, 8'h00);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_reg = S_DAT; host_wdata = 8'hEE;
        @(negedge clk);
        check("R10 busy", {7'd0, host_ready}, 8'h00);
        host_reg = S_LO; host_wdata = 8'h55;
        @(negedge clk);
        host_valid = 1'b0;
        rd_chk("R10 ignored ptr write", S_LO, 8'h41);
        wr(S_LO, 8'h40);
        rd_chk("R10 data kept", S_DAT, 8'hEE);

        // R7 doorbell
        wr(S_CSR, 8'h0B);
        check("R7 doorbell set", {7'd0, cop_irq}, 8'h01);
        rd_chk("R7 csr", S_CSR, 8'h0B);
        wr(S_CSR, 8'h03);
        check("R7 zero no effect", {7'd0, cop_irq}, 8'h01);
        pulse(3);
        check("R7 ack clears", {7'd0, cop_irq}, 8'h00);
        rd_chk("R7 csr after ack", S_CSR, 8'h03);

        // R8 / R9 event flags
        pulse(0);
        check("R8 irq from flag0", {7'd0, host_irq}, 8'h01);
        rd_chk("R8 csr flag0", S_CSR, 8'h13);
        wr(S_CSR, 8'h03);
        rd_chk("R9 zero keeps flag", S_CSR, 8'h13);
        wr(S_CSR, 8'h13);
        check("R9 irq cleared", {7'd0, host_irq}, 8'h00);
        rd_chk("R9 csr cleared", S_CSR, 8'h03);
        pulse(2);
        rd_chk("R8 both flags", S_CSR, 8'h33);
        wr(S_CSR, 8'h13);
        rd_chk("R9 only flag0 cleared", S_CSR, 8'h23);
        check("R8 irq from flag1", {7'd0, host_irq}, 8'h01);
        wr(S_CSR, 8'h23);
        check("R9 flag1 cleared", {7'd0, host_irq}, 8'h00);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_reg = S_CSR; host_wdata = 8'h23;
        cop_int1_set = 1'b1;
        @(negedge clk);
        host_valid = 1'b0; cop_int1_set = 1'b0;
        rd_chk("R9 set wins over clear", S_CSR, 8'h23);
        wr(S_CSR, 8'h23);
        rd_chk("R9 final clear", S_CSR, 8'h03);

        done = 1'b1;
        summary();
    end

endmodule